// File: doc/BRIEF.md
# Sleep, Mute and Bypass Control Arbiter

This block turns a small set of control requests into the three enables that drive an adaptive cable equalizer core. Those enables are power-down, output force-to-zero and equalizer bypass. Each request can come from dedicated pins or from register fields, and a mode-select input chooses which source is live. A digital signal-present input stands in for the analog energy detector. Before it is used, it is synchronised and filtered by a loss timer and a wake timer, both programmable.

The three enables follow a fixed priority. Sleep beats mute, and mute beats bypass. At most one enable is active at a time. The serial data lane is gated to a constant zero whenever the output is muted or the core is powered down. The block also reports carrier state in two senses. One output is active-high on loss, for pin-style wiring: it can be tied straight to a mute request. The other is active-high on presence, for a status register.

Top module: `sleep_mute_arbiter`

## Requirements
- R1: At most one of `pwr_down`, `mute_act` and `bypass_act` is high at any time. A sleep request overrides mute and bypass, and a mute request overrides bypass.
- R2: With `mode_reg` high, `reg_sleep_mode` selects the sleep behaviour. 2'b00 never sleeps. 2'b01 powers down only while the filtered carrier is absent. 2'b10 always powers down. 2'b11 behaves as 2'b00.
- R3: With `mode_reg` low, `pin_auto_sleep` high selects the 2'b01 behaviour and low selects 2'b00. `pin_mute` and `pin_bypass` supply the mute and bypass requests, and the register fields have no effect.
- R4: With `mode_reg` high, the three pin inputs have no effect on any output.
- R5: `dout` is all zeros while `pwr_down` or `mute_act` is high. Otherwise it equals `din` in the same cycle.
- R6: The filtered carrier drops on the clock edge numbered SYNC_STAGES + `off_dly` after `sig_present` falls, counting edges from the fall. `sig_present` must stay low throughout. A dropout shorter than that leaves the carrier state unchanged.
- R7: The filtered carrier returns on the clock edge numbered SYNC_STAGES + `wake_dly` after `sig_present` rises, counting edges from the rise. `sig_present` must stay high throughout.
- R8: A delay value of zero acts as a delay of one cycle.
- R9: `cd_n` is high when the filtered carrier is absent and low when it is present. `carrier_ok` is always its inverse.
- R10: After reset the filtered carrier is absent. So `cd_n` is 1, `carrier_ok` is 0, and in auto sleep `pwr_down` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_reg | input | 1 | 0: pin controls live, 1: register fields live |
| pin_auto_sleep | input | 1 | Pin request for auto sleep |
| pin_mute | input | 1 | Pin request to mute the output |
| pin_bypass | input | 1 | Pin request to bypass the equalizer |
| reg_sleep_mode | input | 2 | Register sleep mode code |
| reg_mute | input | 1 | Register mute request |
| reg_bypass | input | 1 | Register bypass request |
| off_dly | input | CNT_W | Loss timer length in cycles |
| wake_dly | input | CNT_W | Wake timer length in cycles |
| sig_present | input | 1 | Raw signal-present detector |
| din | input | DATA_W | Data lane from the equalizer |
| pwr_down | output | 1 | Core power-down enable |
| mute_act | output | 1 | Output force-to-zero enable |
| bypass_act | output | 1 | Equalizer and DC restore bypass enable |
| dout | output | DATA_W | Gated data lane |
| cd_n | output | 1 | Carrier detect, high on no signal |
| carrier_ok | output | 1 | Carrier status, high on signal |

## Verification
The situations hardest to reach are the exact edge where the loss timer expires and a dropout that ends one count short of that edge. Both depend on how many synchroniser stages and counter cycles separate the raw input from the filtered state. The stimulus changes `sig_present` only at falling clock edges and then counts rising edges. Each timing check therefore samples one edge before and one edge at the predicted flip. A three-cycle dropout against a five-cycle loss window shows that short gaps are ignored. A zero delay setting exercises the minimum-length case.

// File: rtl/sma_pkg.sv
package sma_pkg;
   typedef enum logic [1:0] {
      SLP_NEVER = 2'b00,
      SLP_AUTO  = 2'b01,
      SLP_FORCE = 2'b10,
      SLP_RSVD  = 2'b11
   } slp_mode_e;
endpackage

// File: rtl/sma_sync.sv
module sma_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 0) begin : g_bad
         $error("sma_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_thru
         assign q = d;
      end else if (STAGES == 1) begin : g_one
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= 1'b0;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= {r[STAGES-2:0], d};
         end
         assign q = r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sma_presence_filt.sv
module sma_presence_filt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             det,
   input  logic [CNT_W-1:0] off_dly,
   input  logic [CNT_W-1:0] wake_dly,
   output logic             present
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] dly_raw;
   logic [CNT_W-1:0] dly_eff;
   logic             differ;
   logic             expire;

   // present=1 means the next flip is a loss, so the loss length applies
   assign dly_raw = present ? off_dly : wake_dly;
   assign dly_eff = (dly_raw == '0) ? ONE : dly_raw;
   assign differ  = det ^ present;
   assign expire  = differ && ((cnt + ONE) >= dly_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         present <= 1'b0;
      end else if (!differ) begin
         cnt <= '0;
      end else if (expire) begin
         cnt     <= '0;
         present <= det;
      end else begin
         cnt <= cnt + ONE;
      end
   end

   // R7
   rise_needs_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(present) |-> $past(det));
   // R6
   fall_needs_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(present) |-> !$past(det));
   // R6
   agree_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (det == present) |=> (cnt == '0));
endmodule

// File: rtl/sma_prio.sv
module sma_prio
   import sma_pkg::*;
#(
   parameter int DATA_W = 1
) (
   input  logic              mode_reg,
   input  logic              pin_auto_sleep,
   input  logic              pin_mute,
   input  logic              pin_bypass,
   input  logic [1:0]        reg_sleep_mode,
   input  logic              reg_mute,
   input  logic              reg_bypass,
   input  logic              present,
   input  logic [DATA_W-1:0] din,
   output logic              pwr_down,
   output logic              mute_act,
   output logic              bypass_act,
   output logic [DATA_W-1:0] dout
);
   slp_mode_e sel;
   logic      mute_req;
   logic      byp_req;

   always_comb begin
      if (mode_reg) begin
         unique case (slp_mode_e'(reg_sleep_mode))
            SLP_AUTO:  sel = SLP_AUTO;
            SLP_FORCE: sel = SLP_FORCE;
            default:   sel = SLP_NEVER;
         endcase
         mute_req = reg_mute;
         byp_req  = reg_bypass;
      end else begin
         sel      = pin_auto_sleep ? SLP_AUTO : SLP_NEVER;
         mute_req = pin_mute;
         byp_req  = pin_bypass;
      end
   end

   always_comb begin
      pwr_down   = (sel == SLP_FORCE) || ((sel == SLP_AUTO) && !present);
      mute_act   = !pwr_down && mute_req;
      bypass_act = !pwr_down && !mute_req && byp_req;
   end

   generate
      if (DATA_W < 1) begin : g_bad
         $error("sma_prio: DATA_W must be at least 1");
      end
   endgenerate

   assign dout = (pwr_down || mute_act) ? '0 : din;
endmodule

// File: rtl/sleep_mute_arbiter.sv
module sleep_mute_arbiter #(
   parameter int DATA_W      = 1,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_reg,
   input  logic              pin_auto_sleep,
   input  logic              pin_mute,
   input  logic              pin_bypass,
   input  logic [1:0]        reg_sleep_mode,
   input  logic              reg_mute,
   input  logic              reg_bypass,
   input  logic [CNT_W-1:0]  off_dly,
   input  logic [CNT_W-1:0]  wake_dly,
   input  logic              sig_present,
   input  logic [DATA_W-1:0] din,
   output logic              pwr_down,
   output logic              mute_act,
   output logic              bypass_act,
   output logic [DATA_W-1:0] dout,
   output logic              cd_n,
   output logic              carrier_ok
);
   logic det_q;
   logic present_f;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("sleep_mute_arbiter: CNT_W out of range 2..32");
      end
   endgenerate

   sma_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk (clk), .rst_n (rst_n), .d (sig_present), .q (det_q)
   );

   sma_presence_filt #(.CNT_W(CNT_W)) i_filt (
      .clk (clk), .rst_n (rst_n), .det (det_q),
      .off_dly (off_dly), .wake_dly (wake_dly), .present (present_f)
   );

   sma_prio #(.DATA_W(DATA_W)) i_prio (
      .mode_reg (mode_reg), .pin_auto_sleep (pin_auto_sleep),
      .pin_mute (pin_mute), .pin_bypass (pin_bypass),
      .reg_sleep_mode (reg_sleep_mode), .reg_mute (reg_mute),
      .reg_bypass (reg_bypass), .present (present_f), .din (din),
      .pwr_down (pwr_down), .mute_act (mute_act),
      .bypass_act (bypass_act), .dout (dout)
   );

   assign cd_n       = !present_f;
   assign carrier_ok = present_f;

   // R1
   one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pwr_down, mute_act, bypass_act}));
   // R5
   gated_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_down || mute_act) |-> (dout == '0));
   // R2
   forced_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_reg && reg_sleep_mode == 2'b10) |-> pwr_down);
   // R9
   cd_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cd_n != carrier_ok);
endmodule

// File: tb/test_sleep_mute_arbiter.sv
module test_sleep_mute_arbiter;
   localparam int CLK_PER = 10;
   localparam int CNT_W   = 16;
   localparam int SYNC    = 2;
   localparam int WD_LIM  = 20000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             mode_reg = 1'b0, pin_auto_sleep = 1'b0, pin_mute = 1'b0, pin_bypass = 1'b0;
   logic [1:0]       reg_sleep_mode = 2'b00;
   logic             reg_mute = 1'b0, reg_bypass = 1'b0;
   logic [CNT_W-1:0] off_dly = 16'd5, wake_dly = 16'd3;
   logic             sig_present = 1'b0;
   logic [0:0]       din = 1'b0;
   logic             pwr_down, mute_act, bypass_act, cd_n, carrier_ok;
   logic [0:0]       dout;

   int checks = 0;
   int errors = 0;

   always #(CLK_PER/2) clk = ~clk;

   sleep_mute_arbiter #(.DATA_W(1), .CNT_W(CNT_W), .SYNC_STAGES(SYNC)) i_sleep_mute_arbiter (
      .clk (clk), .rst_n (rst_n), .mode_reg (mode_reg),
      .pin_auto_sleep (pin_auto_sleep), .pin_mute (pin_mute), .pin_bypass (pin_bypass),
      .reg_sleep_mode (reg_sleep_mode), .reg_mute (reg_mute), .reg_bypass (reg_bypass),
      .off_dly (off_dly), .wake_dly (wake_dly), .sig_present (sig_present), .din (din),
      .pwr_down (pwr_down), .mute_act (mute_act), .bypass_act (bypass_act),
      .dout (dout), .cd_n (cd_n), .carrier_ok (carrier_ok)
   );

   // [13]mode [12]pin_auto [11]pin_mute [10]pin_byp [9:8]reg_sleep [7]reg_mute
   // [6]reg_byp [5]carrier [4]din | expected [3]pwr [2]mute [1]byp [0]dout
   localparam logic [13:0] VEC [12] = '{
      14'b0_0_0_0_10_1_1_1_1_0001,  // R3 register fields ignored in pin mode
      14'b0_1_0_0_00_0_0_0_1_1000,  // R3 auto pin, no carrier
      14'b0_1_1_1_00_0_0_1_1_0100,  // R1 mute over bypass
      14'b0_0_0_1_00_0_0_0_1_0011,  // R3 auto off, bypass
      14'b0_0_1_1_00_0_0_0_1_0100,  // R5 mute gates data
      14'b1_1_1_1_00_0_0_0_1_0001,  // R4 pins ignored
      14'b1_0_0_0_01_1_1_0_1_1000,  // R2 auto sleep over mute
      14'b1_0_0_0_01_0_1_1_1_0011,  // R2 auto awake, bypass
      14'b1_0_0_0_10_1_1_1_1_1000,  // R2 forced sleep with carrier
      14'b1_0_0_0_11_0_0_0_1_0001,  // R2 reserved acts as never
      14'b1_0_0_0_11_1_0_0_1_0100,  // R2 reserved, mute live
      14'b1_0_0_0_00_0_0_1_0_0000   // R5 data follows din
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic at_neg();
      @(negedge clk);
   endtask

   initial begin
      repeat (WD_LIM) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      mode_reg = 1'b1; reg_sleep_mode = 2'b01;
      #(CLK_PER*2 + 2);
      // R10 reset state
      chk("R10 cd_n", {31'b0, cd_n}, 32'd1);
      chk("R10 carrier_ok", {31'b0, carrier_ok}, 32'd0);
      chk("R10 pwr_down", {31'b0, pwr_down}, 32'd1);
      at_neg(); rst_n = 1'b1;
      edges(3);
      chk("R10 after release", {31'b0, carrier_ok}, 32'd0);

      for (int i = 0; i < 12; i++) begin
         at_neg();
         sig_present = VEC[i][5];
         edges(20);
         at_neg();
         {mode_reg, pin_auto_sleep, pin_mute, pin_bypass} = VEC[i][13:10];
         reg_sleep_mode = VEC[i][9:8];
         {reg_mute, reg_bypass} = VEC[i][7:6];
         din = VEC[i][4];
         #1;
         // R1 R2 R3 R4 R5
         chk($sformatf("R1 arbitration row %0d", i),
             {28'b0, pwr_down, mute_act, bypass_act, dout[0]}, {28'b0, VEC[i][3:0]});
         // R9
         chk($sformatf("R9 carrier sense row %0d", i),
             {30'b0, cd_n, carrier_ok}, {30'b0, !VEC[i][5], VEC[i][5]});
      end

      // R6 exact loss edge
      mode_reg = 1'b1; reg_sleep_mode = 2'b01; reg_mute = 0; reg_bypass = 0;
      at_neg(); sig_present = 1'b1; edges(20);
      at_neg(); sig_present = 1'b0;
      edges(SYNC + 5 - 1);
      chk("R6 before loss edge", {31'b0, carrier_ok}, 32'd1);
      edges(1);
      chk("R6 at loss edge", {31'b0, carrier_ok}, 32'd0);
      chk("R6 auto sleep engaged", {31'b0, pwr_down}, 32'd1);

      // R7 exact wake edge
      at_neg(); sig_present = 1'b1;
      edges(SYNC + 3 - 1);
      chk("R7 before wake edge", {31'b0, carrier_ok}, 32'd0);
      edges(1);
      chk("R7 at wake edge", {31'b0, carrier_ok}, 32'd1);
      chk("R7 powered up", {31'b0, pwr_down}, 32'd0);

      // R6 short dropout ignored
      edges(10);
      at_neg(); sig_present = 1'b0;
      repeat (3) @(posedge clk);
      at_neg(); sig_present = 1'b1;
      begin
         int drops = 0;
         for (int k = 0; k < 15; k++) begin
            edges(1);
            if (carrier_ok !== 1'b1) drops++;
         end
         chk("R6 short dropout ignored", drops, 0);
      end

      // R8 zero delay acts as one
      off_dly = '0;
      at_neg(); sig_present = 1'b0;
      edges(SYNC);
      chk("R8 zero delay not yet", {31'b0, carrier_ok}, 32'd1);
      edges(1);
      chk("R8 zero delay flips", {31'b0, carrier_ok}, 32'd0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule